// File: doc/BRIEF.md
# Coefficient Safeload Commit Controller

This block lets a host stage a small batch of DSP parameter updates and then have them all land in the parameter RAM together, between two audio frames. The DSP core never runs a frame with only some of a filter's coefficients updated. Five staging entries exist. Each entry pairs a 40-bit data word with a 16-bit parameter RAM address. By convention the top byte of the data word is zero and the low four bytes carry the coefficient.

The host writes data words and target addresses through a register write port and can read them back. It then sets the start bit in the control register. The block waits for the next frame-sync strobe. On that strobe it copies every entry written since the previous commit to the RAM write port, one per clock, lowest entry first. It then drops the start bit. While the start bit reads as set, the staging entries are locked. The host polls that bit before staging the next batch.

Top module: `safeload_ctrl`

## Requirements
- R1: After a synchronous active-low reset, the start bit reads 0, every staging entry reads 0, no entry counts as written, and `ram_we` is 0.
- R2: Register address 0x0810+i (i = 0..4) holds the 40-bit data word of entry i. Address 0x0815+i holds the 16-bit target address of entry i, taken from the low 16 bits of `reg_wdata`. Both read back on `reg_rdata` combinationally, with the target address zero-extended. Any other address except 0x081C reads 0.
- R3: A write to the control register at 0x081C with bit 5 = 1, made while the bit is clear, sets the start bit. Reading 0x081C returns bit 5 as the start bit and all other bits as 0.
- R4: While the start bit is set and no commit is running, no RAM write occurs until a `frame_sync` pulse. A `frame_sync` in the same cycle as the start write does not begin the commit.
- R5: On the first `frame_sync` after the start bit is set, each entry written since the last commit produces exactly one RAM write, carrying that entry's latest target address and data word. The writes run in ascending entry order on consecutive cycles, and the first one appears in the cycle after the `frame_sync` edge.
- R6: The start bit reads 0 from the same cycle in which the final RAM write of a commit is presented, and not earlier.
- R7: Writes to data or target-address entries are ignored while the start bit is set. Their contents and their written marks stay unchanged.
- R8: A commit clears all written marks. If no entry was written, the `frame_sync` clears the start bit with no RAM write.
- R9: A write to 0x081C with bit 5 = 0 does not start a commit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 16 | Register address for write and read |
| reg_wdata | input | 40 | Register write data |
| reg_rdata | output | 40 | Combinational read data for `reg_addr` |
| frame_sync | input | 1 | One-cycle audio frame boundary strobe |
| ram_we | output | 1 | Parameter RAM write enable |
| ram_addr | output | 16 | Parameter RAM write address |
| ram_wdata | output | 40 | Parameter RAM write data |

## Verification
Directed batches cover four cases: one isolated entry, all five entries written in reverse order, an empty batch, and a batch whose entries are rewritten while locked. These separate correct ascending ordering from write-order replay, and they separate real tracking of written entries from copying all five. A start write that coincides with `frame_sync` and a control write with bit 5 clear show that only a later strobe, after a real start, launches the copy. Seeded random batches then write random subsets of entries, some more than once, to show that only the latest value of each written entry is copied, and only once. The start bit is sampled alongside every captured RAM write to place its fall exactly on the final write.

// File: rtl/safeload_pkg.sv
// Shared constants and state type for the safeload commit controller.
// Assumes a 16-bit register address space; the entry count is set at the top.
package safeload_pkg;
    typedef enum logic [1:0] {
        SL_IDLE  = 2'd0,
        SL_ARMED = 2'd1,
        SL_COPY  = 2'd2
    } sl_state_e;

    localparam logic [15:0] SL_DATA_BASE = 16'h0810;
    localparam logic [15:0] SL_CTRL_ADDR = 16'h081C;
    localparam int          SL_START_BIT = 5;
endpackage

// File: rtl/safeload_stage.sv
// Staging entries: data words, target addresses and per-entry written marks.
// Decodes host writes to the data window and the target window that follows it.
// Assumes lock is high for the whole pending and copy window. clr_mask only
// pulses while lock is high, so a set and a clear never meet on one entry.
module safeload_stage #(
    parameter int NUM_SLOTS = 5,
    parameter int DATA_W    = 40,
    parameter int TGT_W     = 16,
    parameter int REG_AW    = 16
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                wr_en,
    input  logic [REG_AW-1:0]                   addr,
    input  logic [DATA_W-1:0]                   wdata,
    input  logic                                lock,
    input  logic [NUM_SLOTS-1:0]                clr_mask,
    output logic [NUM_SLOTS-1:0][DATA_W-1:0]    slot_data,
    output logic [NUM_SLOTS-1:0][TGT_W-1:0]     slot_tgt,
    output logic [NUM_SLOTS-1:0]                dirty,
    output logic [DATA_W-1:0]                   rd_data
);
    timeunit 1ns; timeprecision 1ps;
    import safeload_pkg::*;

    localparam logic [REG_AW-1:0] DATA_LO = REG_AW'(SL_DATA_BASE);
    localparam logic [REG_AW-1:0] TGT_LO  = REG_AW'(SL_DATA_BASE + NUM_SLOTS);

    for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
        localparam logic [REG_AW-1:0] D_ADDR = DATA_LO + REG_AW'(s);
        localparam logic [REG_AW-1:0] T_ADDR = TGT_LO + REG_AW'(s);
        logic hit_d;
        logic hit_t;
        assign hit_d = wr_en && !lock && (addr == D_ADDR);
        assign hit_t = wr_en && !lock && (addr == T_ADDR);

        // Capture the data word of this entry.
        always_ff @(posedge clk) begin
            if (!rst_n)     slot_data[s] <= '0;
            else if (hit_d) slot_data[s] <= wdata;
        end

        // Capture the target address of this entry.
        always_ff @(posedge clk) begin
            if (!rst_n)     slot_tgt[s] <= '0;
            else if (hit_t) slot_tgt[s] <= wdata[TGT_W-1:0];
        end

        // Mark the entry written; clear the mark when the sequencer copies it.
        always_ff @(posedge clk) begin
            if (!rst_n)              dirty[s] <= 1'b0;
            else if (hit_d || hit_t) dirty[s] <= 1'b1;
            else if (clr_mask[s])    dirty[s] <= 1'b0;
        end
    end

    // Readback multiplexer for both entry windows.
    always_comb begin
        rd_data = '0;
        for (int s = 0; s < NUM_SLOTS; s++) begin
            if (addr == DATA_LO + REG_AW'(s)) rd_data = slot_data[s];
            if (addr == TGT_LO + REG_AW'(s))  rd_data = DATA_W'(slot_tgt[s]);
        end
    end
endmodule

// File: rtl/safeload_seq.sv
// Commit sequencer: holds the start bit, waits for the frame strobe, then
// copies written entries lowest-first to a registered RAM write port.
// Assumes dirty stays stable apart from the clears this module requests.
module safeload_seq #(
    parameter int NUM_SLOTS = 5,
    parameter int DATA_W    = 40,
    parameter int TGT_W     = 16
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                start_req,
    input  logic                                frame_sync,
    input  logic [NUM_SLOTS-1:0]                dirty,
    input  logic [NUM_SLOTS-1:0][DATA_W-1:0]    slot_data,
    input  logic [NUM_SLOTS-1:0][TGT_W-1:0]     slot_tgt,
    output logic                                ist,
    output logic                                committing,
    output logic [NUM_SLOTS-1:0]                clr_mask,
    output logic                                ram_we,
    output logic [TGT_W-1:0]                    ram_addr,
    output logic [DATA_W-1:0]                   ram_wdata
);
    timeunit 1ns; timeprecision 1ps;
    import safeload_pkg::*;

    localparam int IDX_W = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1;

    sl_state_e              state;
    logic [NUM_SLOTS-1:0]   pick_oh;
    logic [NUM_SLOTS-1:0]   remaining;
    logic [IDX_W-1:0]       pick_idx;
    logic                   step;

    // Lowest written entry as one-hot and as an index.
    always_comb begin
        pick_oh  = dirty & (~dirty + NUM_SLOTS'(1));
        pick_idx = '0;
        for (int s = NUM_SLOTS - 1; s >= 0; s--) begin
            if (dirty[s]) pick_idx = IDX_W'(s);
        end
    end

    // Copy step: on the strobe while armed, then every cycle while copying.
    always_comb begin
        step      = ((state == SL_ARMED) && frame_sync) || (state == SL_COPY);
        remaining = dirty & ~pick_oh;
        clr_mask  = step ? pick_oh : '0;
    end

    // Control state: idle, armed waiting for the strobe, copying.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= SL_IDLE;
        end else begin
            case (state)
                SL_IDLE:  if (start_req)  state <= SL_ARMED;
                SL_ARMED: if (frame_sync) state <= (remaining != '0) ? SL_COPY : SL_IDLE;
                SL_COPY:  if (remaining == '0) state <= SL_IDLE;
                default:  state <= SL_IDLE;
            endcase
        end
    end

    // Registered RAM write port, loaded with the picked entry on each step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ram_we    <= 1'b0;
            ram_addr  <= '0;
            ram_wdata <= '0;
        end else begin
            ram_we <= step && (dirty != '0);
            if (step) begin
                ram_addr  <= slot_tgt[pick_idx];
                ram_wdata <= slot_data[pick_idx];
            end
        end
    end

    assign ist        = (state != SL_IDLE);
    assign committing = (state == SL_COPY);
endmodule

// File: rtl/safeload_ctrl.sv
// Top of the safeload commit controller: control register decode, start bit
// readback, staging entries and commit sequencer.
// Assumes one register access per cycle and a single-cycle frame_sync.
module safeload_ctrl #(
    parameter int NUM_SLOTS = 5,
    parameter int DATA_W    = 40,
    parameter int TGT_W     = 16,
    parameter int REG_AW    = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              frame_sync,
    output logic              ram_we,
    output logic [TGT_W-1:0]  ram_addr,
    output logic [DATA_W-1:0] ram_wdata
);
    timeunit 1ns; timeprecision 1ps;
    import safeload_pkg::*;

    localparam logic [REG_AW-1:0] CTRL_A = REG_AW'(SL_CTRL_ADDR);

    logic [NUM_SLOTS-1:0][DATA_W-1:0] slot_data;
    logic [NUM_SLOTS-1:0][TGT_W-1:0]  slot_tgt;
    logic [NUM_SLOTS-1:0]             dirty;
    logic [NUM_SLOTS-1:0]             clr_mask;
    logic [DATA_W-1:0]                stage_rd;
    logic                             ist;
    logic                             committing;
    logic                             ctrl_hit;
    logic                             start_req;

    // Control register decode: only the start bit has an effect.
    always_comb begin
        ctrl_hit  = (reg_addr == CTRL_A);
        start_req = reg_we && ctrl_hit && reg_wdata[SL_START_BIT];
    end

    // Read path: start bit at its position for the control register.
    always_comb begin
        if (ctrl_hit)
            reg_rdata = {{(DATA_W-SL_START_BIT-1){1'b0}}, ist, {SL_START_BIT{1'b0}}};
        else
            reg_rdata = stage_rd;
    end

    safeload_stage #(
        .NUM_SLOTS(NUM_SLOTS), .DATA_W(DATA_W), .TGT_W(TGT_W), .REG_AW(REG_AW)
    ) u_stage (
        .clk(clk), .rst_n(rst_n), .wr_en(reg_we), .addr(reg_addr),
        .wdata(reg_wdata), .lock(ist), .clr_mask(clr_mask),
        .slot_data(slot_data), .slot_tgt(slot_tgt), .dirty(dirty),
        .rd_data(stage_rd)
    );

    safeload_seq #(
        .NUM_SLOTS(NUM_SLOTS), .DATA_W(DATA_W), .TGT_W(TGT_W)
    ) u_seq (
        .clk(clk), .rst_n(rst_n), .start_req(start_req), .frame_sync(frame_sync),
        .dirty(dirty), .slot_data(slot_data), .slot_tgt(slot_tgt),
        .ist(ist), .committing(committing), .clr_mask(clr_mask),
        .ram_we(ram_we), .ram_addr(ram_addr), .ram_wdata(ram_wdata)
    );
endmodule

// File: rtl/safeload_chk.sv
// Temporal checks on the safeload controller, bound into every instance.
module safeload_chk #(
    parameter int NUM_SLOTS = 5
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 frame_sync,
    input logic                 ram_we,
    input logic                 ist,
    input logic                 committing,
    input logic [NUM_SLOTS-1:0] dirty
);
    timeunit 1ns; timeprecision 1ps;

    AST_RESET_CLEAN: assert property (@(posedge clk) !rst_n |=> (!ist && !ram_we && dirty == '0)); // R1
    AST_ARMED_WAITS: assert property (@(posedge clk) disable iff (!rst_n) (ist && !committing && !frame_sync) |=> (ist && !ram_we)); // R4
    AST_WRITE_NEEDS_START: assert property (@(posedge clk) disable iff (!rst_n) ram_we |-> $past(ist)); // R5
    AST_BURST_CONTIGUOUS: assert property (@(posedge clk) disable iff (!rst_n) (ram_we && ist) |=> ram_we); // R5
    AST_LAST_WRITE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n) (ram_we && !ist) |=> !ram_we); // R6
    AST_LOCKED_NO_NEW_MARK: assert property (@(posedge clk) disable iff (!rst_n) ist |=> ($countones(dirty) <= $countones($past(dirty)))); // R7
endmodule

bind safeload_ctrl safeload_chk #(.NUM_SLOTS(NUM_SLOTS)) u_chk (
    .clk(clk), .rst_n(rst_n), .frame_sync(frame_sync), .ram_we(ram_we),
    .ist(ist), .committing(committing), .dirty(dirty)
);

// File: tb/sim_safeload_ctrl.sv
// Bench for safeload_ctrl: directed corner cases plus seeded random batches.
module sim_safeload_ctrl;
    timeunit 1ns; timeprecision 1ps;

    localparam int NS = 5;
    localparam int DW = 40;
    localparam int TW = 16;
    localparam logic [15:0] CTRL = 16'h081C;
    localparam logic [15:0] DBASE = 16'h0810;
    localparam logic [15:0] TBASE = 16'h0815;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          reg_we = 1'b0;
    logic          frame_sync = 1'b0;
    logic [15:0]   reg_addr = 16'h081C;
    logic [DW-1:0] reg_wdata = '0;
    logic [DW-1:0] reg_rdata;
    logic          ram_we;
    logic [TW-1:0] ram_addr;
    logic [DW-1:0] ram_wdata;

    int checks = 0;
    int errs = 0;
    logic [DW-1:0] m_data [NS];
    logic [TW-1:0] m_tgt [NS];
    bit            m_dirty [NS];
    logic [TW-1:0] cap_addr [16];
    logic [DW-1:0] cap_data [16];
    bit            cap_ist [16];
    int            cap_n = 0;

    always #2 clk = ~clk;

    safeload_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .frame_sync(frame_sync),
        .ram_we(ram_we), .ram_addr(ram_addr), .ram_wdata(ram_wdata)
    );

    // Record every RAM write together with the start bit seen in that cycle.
    always @(negedge clk) begin
        if (rst_n && ram_we) begin
            if (cap_n < 16) begin
                cap_addr[cap_n] = ram_addr;
                cap_data[cap_n] = ram_wdata;
                cap_ist[cap_n]  = (reg_addr == CTRL) ? reg_rdata[5] : 1'b1;
            end
            cap_n = cap_n + 1;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic report();
        $display("Result: errors=%0d of %0d checks", errs, checks);
    endtask

    task automatic reg_write(input logic [15:0] a, input logic [DW-1:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0; reg_addr = CTRL;
    endtask

    task automatic reg_read(input logic [15:0] a, output logic [DW-1:0] v);
        @(negedge clk);
        reg_addr = a;
        #1 v = reg_rdata;
    endtask

    task automatic stage_data(input int s, input logic [DW-1:0] v);
        reg_write(DBASE + 16'(s), v);
        m_data[s] = v; m_dirty[s] = 1'b1;
    endtask

    task automatic stage_tgt(input int s, input logic [TW-1:0] v);
        reg_write(TBASE + 16'(s), DW'(v));
        m_tgt[s] = v; m_dirty[s] = 1'b1;
    endtask

    // Check a pending start: bit readable as set, nothing written yet.
    task automatic check_pending();
        logic [DW-1:0] v;
        reg_read(CTRL, v);
        chk(v == DW'(32'h20), "R3", "start bit set", v, 64'h20);
        repeat (3) @(negedge clk);
        chk(cap_n == 0, "R4", "no write before strobe", 64'(cap_n), 0);
        reg_read(CTRL, v);
        chk(v == DW'(32'h20), "R4", "still pending", v, 64'h20);
    endtask

    task automatic arm();
        cap_n = 0;
        reg_write(CTRL, DW'(32'h20));
        check_pending();
    endtask

    // Pulse the strobe and compare the burst with the model.
    task automatic fire_and_check();
        logic [DW-1:0] v;
        int n;
        int idx [NS];
        reg_addr = CTRL;
        @(negedge clk); frame_sync = 1'b1;
        @(negedge clk); frame_sync = 1'b0;
        repeat (NS + 3) @(negedge clk);
        n = 0;
        for (int s = 0; s < NS; s++) if (m_dirty[s]) begin idx[n] = s; n++; end
        chk(cap_n == n, (n == 0) ? "R8" : "R5", "write count", 64'(cap_n), 64'(n));
        for (int i = 0; i < n && i < cap_n; i++) begin
            chk(cap_addr[i] == m_tgt[idx[i]], "R5", "ram_addr order", cap_addr[i], m_tgt[idx[i]]);
            chk(cap_data[i] == m_data[idx[i]], "R5", "ram_wdata order", cap_data[i], m_data[idx[i]]);
            chk(cap_ist[i] == (i != n - 1), "R6", "start bit at write", 64'(cap_ist[i]), 64'(i != n - 1));
        end
        reg_read(CTRL, v);
        chk(v == '0, (n == 0) ? "R8" : "R6", "start bit cleared", v, 0);
        for (int s = 0; s < NS; s++) m_dirty[s] = 1'b0;
        cap_n = 0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errs++; checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        report();
        $finish;
    end

    initial begin
        logic [DW-1:0] v;
        for (int s = 0; s < NS; s++) begin m_data[s] = '0; m_tgt[s] = '0; m_dirty[s] = 1'b0; end
        void'($urandom(32'd4242));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        reg_read(CTRL, v);  chk(v == '0, "R1", "ctrl after reset", v, 0);
        reg_read(DBASE, v); chk(v == '0, "R1", "data0 after reset", v, 0);
        reg_read(TBASE + 16'd4, v); chk(v == '0, "R1", "tgt4 after reset", v, 0);
        chk(ram_we == 1'b0, "R1", "ram_we after reset", 64'(ram_we), 0);

        // R2: readback of both windows and an unmapped address
        stage_data(2, {8'h00, 32'hDEADBEEF});
        stage_tgt(2, 16'h03A5);
        reg_read(DBASE + 16'd2, v); chk(v == m_data[2], "R2", "data2 readback", v, m_data[2]);
        reg_read(TBASE + 16'd2, v); chk(v == DW'(m_tgt[2]), "R2", "tgt2 readback", v, 64'(m_tgt[2]));
        reg_read(16'h0820, v); chk(v == '0, "R2", "unmapped reads zero", v, 0);

        // R9: control write without the start bit, then a strobe
        cap_n = 0;
        reg_write(CTRL, DW'(32'h1F));
        reg_read(CTRL, v); chk(v == '0, "R9", "no start", v, 0);
        @(negedge clk); frame_sync = 1'b1; @(negedge clk); frame_sync = 1'b0;
        repeat (4) @(negedge clk);
        chk(cap_n == 0, "R9", "no write without start", 64'(cap_n), 0);

        // R5 R6: single written entry
        arm();
        fire_and_check();

        // R5: all entries written in reverse order, copied in ascending order
        for (int s = NS - 1; s >= 0; s--) begin
            stage_tgt(s, 16'(16'h0100 + s * 7));
            stage_data(s, {8'h00, 32'(32'h11110000 + s)});
        end
        arm();
        fire_and_check();

        // R7: staging writes while pending are ignored
        stage_data(3, {8'h00, 32'hCAFE0003});
        stage_tgt(3, 16'h0033);
        arm();
        reg_write(DBASE + 16'd1, {8'h00, 32'h0BADF00D});
        reg_write(TBASE + 16'd1, DW'(16'h0777));
        reg_read(DBASE + 16'd1, v); chk(v == m_data[1], "R7", "data1 unchanged", v, m_data[1]);
        reg_read(TBASE + 16'd1, v); chk(v == DW'(m_tgt[1]), "R7", "tgt1 unchanged", v, 64'(m_tgt[1]));
        fire_and_check();

        // R8: empty commit
        arm();
        fire_and_check();

        // R4: strobe in the same cycle as the start write is not taken
        stage_data(0, {8'h00, 32'h00C0FFEE});
        cap_n = 0;
        @(negedge clk);
        reg_we = 1'b1; reg_addr = CTRL; reg_wdata = DW'(32'h20); frame_sync = 1'b1;
        @(negedge clk);
        reg_we = 1'b0; frame_sync = 1'b0;
        check_pending();
        fire_and_check();

        // Random batches, some entries rewritten, some batches empty
        for (int r = 0; r < 20; r++) begin
            if (r % 5 != 4) begin
                int k;
                k = $urandom_range(1, 8);
                for (int j = 0; j < k; j++) begin
                    int s;
                    s = $urandom_range(0, NS - 1);
                    if ($urandom_range(0, 1) == 0)
                        stage_data(s, {8'h00, 32'($urandom())});
                    else
                        stage_tgt(s, 16'($urandom()));
                end
            end
            arm();
            fire_and_check();
        end

        report();
        $finish;
    end
endmodule